// File: doc/BRIEF.md
# PHY Configuration Register Bank with Atomic Bit Aliases

This block is a memory-mapped bank of 32-bit configuration and status words for a PHY. Most writable words sit at the base of a four-word group whose other three addresses act as atomic bit-manipulation aliases. A write to the second word ORs its data into the base word, the third clears the bits given, and the fourth inverts them. Software can then change single fields without a read-modify-write sequence. Reading any alias returns the base word.

One bit in the control word is a self-triggered soft reset. When it fires, the power, transmit, receive and control words go back to their power-on values. The status and debug words keep their contents. The bus is a simple word-aligned register port with address, write enable, write data, read enable and registered read data. Each writable word also drives an output port of its own.

Top module: `phy_csr_bank`

## Requirements
- R1: After the synchronous reset, reads return these values. Power config (0x000) 0x001E1C00. Tx config (0x010) 0x10060607. Rx config (0x020) 0x00000000. Control (0x030) 0xC0200000. Status (0x040) 0x00000000. Debug (0x050) 0x7F180000. Debug status (0x060) 0x00000000. Debug 1 (0x070) 0x00001000. Revision (0x080) 0x04020000.
- R2: A write to the base address of a writable word stores the data. The writable words are power, tx, rx, control, status, debug and debug 1. The stored value appears on reads and on that word's output port from the next cycle on.
- R3: A write to base+0x4 of an aliased group ORs the data into the base word.
- R4: A write to base+0x8 of an aliased group clears, in the base word, every bit that is 1 in the data.
- R5: A write to base+0xC of an aliased group XORs the data into the base word.
- R6: A read at base+0x4, +0x8 or +0xC of an aliased group returns the base word. Power, tx, rx, control, debug and debug 1 are the aliased groups.
- R7: Writes to debug status (0x060) and revision (0x080) have no effect. The alias slots of status, debug status and revision (for example 0x044) ignore writes and read 0. Every address at or above 0x090 reads 0.
- R8: A soft reset fires when a write to control base (0x030) or control set (0x034) has bit 31 of the data set. The soft reset reloads power, tx, rx and control with their R1 values. In the same cycle, these values win over the written data.
- R9: A write to control toggle (0x03C) fires a soft reset only if data bit 31 is 1 and control bit 31 is 1 after the toggle. A write to control clear (0x038) never fires one.
- R10: A soft reset leaves status, debug and debug 1 unchanged.
- R11: Read data is registered. It reflects the bank as it stands at the cycle where the read is enabled, appears one cycle later, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte address, word aligned |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| pwr_cfg | output | 32 | Power config word |
| tx_cfg | output | 32 | Transmit config word |
| rx_cfg | output | 32 | Receive config word |
| ctl | output | 32 | Control word |
| stat | output | 32 | Status word |
| dbg | output | 32 | Debug word |
| dbg1 | output | 32 | Debug 1 word |

## Verification
The alias operations are driven with data that overlaps the existing word only in part. A wrong operator choice then gives a value distinct from every other operator. The soft reset is tried four ways, each with a marker left in the receive word beforehand. Those are a direct control write, a set-alias write, a toggle that clears bit 31, and a toggle that sets it. A fifth case is a clear write, and two controls are a control write without bit 31 and a clear of bit 31. The marker shows whether the reload happened, and pre-loaded debug and status words show that it stayed within its subset. Writes to read-only words and to missing alias slots are followed by reads that separate "ignored" from "aliased to the base".

// File: rtl/phy_csr_pkg.sv
package phy_csr_pkg;
  localparam int DATA_W       = 32;
  localparam int NUM_GRP      = 9;
  localparam int SOFT_RST_BIT = 31;

  localparam int G_PWR  = 0;
  localparam int G_TX   = 1;
  localparam int G_RX   = 2;
  localparam int G_CTL  = 3;
  localparam int G_STAT = 4;
  localparam int G_DBG  = 5;
  localparam int G_DBGS = 6;
  localparam int G_DBG1 = 7;
  localparam int G_REV  = 8;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_TOG = 2'd3
  } csr_op_e;

  function automatic logic [DATA_W-1:0] grp_rst_val(input int g);
    case (g)
      G_PWR:   return 32'h001E_1C00;
      G_TX:    return 32'h1006_0607;
      G_CTL:   return 32'hC020_0000;
      G_DBG:   return 32'h7F18_0000;
      G_DBG1:  return 32'h0000_1000;
      G_REV:   return 32'h0402_0000;
      default: return '0;
    endcase
  endfunction

  function automatic logic grp_has_alias(input int g);
    return (g == G_PWR) || (g == G_TX) || (g == G_RX) || (g == G_CTL) ||
           (g == G_DBG) || (g == G_DBG1);
  endfunction

  function automatic logic grp_writable(input int g);
    return grp_has_alias(g) || (g == G_STAT);
  endfunction

  function automatic logic grp_soft_rst(input int g);
    return (g == G_PWR) || (g == G_TX) || (g == G_RX) || (g == G_CTL);
  endfunction
endpackage

// File: rtl/csr_addr_dec.sv
module csr_addr_dec
  import phy_csr_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int GRP_W = ADDR_W - 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [GRP_W-1:0]  grp,
  output csr_op_e           op,
  output logic              in_map
);
  logic [1:0] lo_unused;

  assign grp       = addr[ADDR_W-1:4];
  assign op        = csr_op_e'(addr[3:2]);
  assign lo_unused = addr[1:0];
  assign in_map    = (grp < GRP_W'(NUM_GRP));
endmodule

// File: rtl/csr_alias_reg.sv
module csr_alias_reg
  import phy_csr_pkg::*;
#(
  parameter int              W        = 32,
  parameter logic [W-1:0]    RST_VAL  = '0,
  parameter bit              ALIAS_EN = 1'b1,
  parameter bit              SOFT_EN  = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  csr_op_e      op,
  input  logic [W-1:0] wdata,
  input  logic         soft_rst,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  logic upd;

  always_comb begin
    case (op)
      OP_SET:  nxt = q | wdata;
      OP_CLR:  nxt = q & ~wdata;
      OP_TOG:  nxt = q ^ wdata;
      default: nxt = wdata;
    endcase
  end

  assign upd = sel && (ALIAS_EN || (op == OP_WR));

  always_ff @(posedge clk) begin
    if (rst)                    q <= RST_VAL;
    else if (SOFT_EN && soft_rst) q <= RST_VAL;
    else if (upd)               q <= nxt;
  end

  // R3: bits given to the set alias are 1 afterwards
  assert_set_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (sel && ALIAS_EN && op == OP_SET && !(SOFT_EN && soft_rst))
      |=> ((q & $past(wdata)) == $past(wdata)));

  // R4: bits given to the clear alias are 0 afterwards
  assert_clr_bits_R4: assert property (@(posedge clk) disable iff (rst)
    (sel && ALIAS_EN && op == OP_CLR && !(SOFT_EN && soft_rst))
      |=> ((q & $past(wdata)) == '0));

  // R5: toggle alias inverts exactly the given bits
  assert_tog_bits_R5: assert property (@(posedge clk) disable iff (rst)
    (sel && ALIAS_EN && op == OP_TOG && !(SOFT_EN && soft_rst))
      |=> ((q ^ $past(q)) == $past(wdata)));

  // R7: an unselected word holds its value
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!sel && !(SOFT_EN && soft_rst)) |=> $stable(q));
endmodule

// File: rtl/phy_csr_bank.sv
module phy_csr_bank
  import phy_csr_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int GRP_W = ADDR_W - 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic [31:0]       pwr_cfg,
  output logic [31:0]       tx_cfg,
  output logic [31:0]       rx_cfg,
  output logic [31:0]       ctl,
  output logic [31:0]       stat,
  output logic [31:0]       dbg,
  output logic [31:0]       dbg1
);
  logic [GRP_W-1:0]  grp;
  csr_op_e           op;
  logic              in_map;
  logic [31:0]       reg_q   [NUM_GRP];
  logic [31:0]       reg_nxt [NUM_GRP];
  logic [NUM_GRP-1:0] sel;
  logic              soft_rst;
  logic [31:0]       rd_mux;
  logic              rd_hit;

  csr_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (addr),
    .grp    (grp),
    .op     (op),
    .in_map (in_map)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_word
    assign sel[g] = wr_en && in_map && (grp == GRP_W'(g));
    if (grp_writable(g)) begin : g_rw
      csr_alias_reg #(
        .W        (32),
        .RST_VAL  (grp_rst_val(g)),
        .ALIAS_EN (grp_has_alias(g)),
        .SOFT_EN  (grp_soft_rst(g))
      ) u_reg (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel[g]),
        .op       (op),
        .wdata    (wr_data),
        .soft_rst (soft_rst),
        .q        (reg_q[g]),
        .nxt      (reg_nxt[g])
      );
    end else begin : g_ro
      assign reg_q[g]   = grp_rst_val(g);
      assign reg_nxt[g] = grp_rst_val(g);
    end
  end

  // soft reset: base or set write with the bit, or a toggle leaving it 1
  always_comb begin
    soft_rst = 1'b0;
    if (sel[G_CTL] && wr_data[SOFT_RST_BIT]) begin
      case (op)
        OP_WR, OP_SET: soft_rst = 1'b1;
        OP_TOG:        soft_rst = reg_nxt[G_CTL][SOFT_RST_BIT];
        default:       soft_rst = 1'b0;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (grp == GRP_W'(g)) rd_mux = reg_q[g];
    end
  end

  assign rd_hit = in_map && ((op == OP_WR) || grp_has_alias(int'(grp)));

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_en)  rd_data <= rd_hit ? rd_mux : '0;
  end

  assign pwr_cfg = reg_q[G_PWR];
  assign tx_cfg  = reg_q[G_TX];
  assign rx_cfg  = reg_q[G_RX];
  assign ctl     = reg_q[G_CTL];
  assign stat    = reg_q[G_STAT];
  assign dbg     = reg_q[G_DBG];
  assign dbg1    = reg_q[G_DBG1];

  // R8: a fired soft reset leaves the reload subset at its defaults
  assert_soft_reload_R8: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (pwr_cfg == 32'h001E_1C00 && tx_cfg == 32'h1006_0607 &&
                  rx_cfg == 32'h0 && ctl == 32'hC020_0000));

  // R9: the clear alias of control never fires a soft reset
  assert_clr_no_rst_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(12'h038)) |-> !soft_rst);

  // R10: words outside the subset survive a soft reset
  assert_keep_R10: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> ($stable(stat) && $stable(dbg) && $stable(dbg1)));

  // R7: unmapped reads return zero
  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !in_map) |=> (rd_data == 32'h0));

  // R11: read data holds between reads
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/test_phy_csr_bank.sv
`timescale 1ns/1ps
module test_phy_csr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data, pwr_cfg, tx_cfg, rx_cfg, ctl, stat, dbg, dbg1;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  phy_csr_bank i_phy_csr_bank (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pwr_cfg(pwr_cfg), .tx_cfg(tx_cfg),
    .rx_cfg(rx_cfg), .ctl(ctl), .stat(stat), .dbg(dbg), .dbg1(dbg1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    rd_chk("R1 pwr", 12'h000, 32'h001E_1C00);
    rd_chk("R1 tx",  12'h010, 32'h1006_0607);
    rd_chk("R1 rx",  12'h020, 32'h0);
    rd_chk("R1 ctl", 12'h030, 32'hC020_0000);
    rd_chk("R1 stat",12'h040, 32'h0);
    rd_chk("R1 dbg", 12'h050, 32'h7F18_0000);
    rd_chk("R1 dbgs",12'h060, 32'h0);
    rd_chk("R1 dbg1",12'h070, 32'h0000_1000);
    rd_chk("R1 rev", 12'h080, 32'h0402_0000);
    chk("R1 ctl port", ctl, 32'hC020_0000);
  endtask

  task automatic t_direct;
    bus_wr(12'h010, 32'h1234_5678);
    chk("R2 tx port", tx_cfg, 32'h1234_5678);
    rd_chk("R2 tx read", 12'h010, 32'h1234_5678);
    bus_wr(12'h040, 32'hA5A5_0001);
    rd_chk("R2 stat read", 12'h040, 32'hA5A5_0001);
  endtask

  task automatic t_set;
    bus_wr(12'h004, 32'h0000_00F0);
    rd_chk("R3 set", 12'h000, 32'h001E_1CF0);
    rd_chk("R6 alias+4", 12'h004, 32'h001E_1CF0);
    rd_chk("R6 alias+8", 12'h008, 32'h001E_1CF0);
    rd_chk("R6 alias+C", 12'h00C, 32'h001E_1CF0);
  endtask

  task automatic t_clr;
    bus_wr(12'h008, 32'h0000_1C10);
    rd_chk("R4 clr", 12'h000, 32'h001E_00E0);
    chk("R4 port", pwr_cfg, 32'h001E_00E0);
  endtask

  task automatic t_tog;
    bus_wr(12'h01C, 32'hFFFF_0000);
    rd_chk("R5 tog", 12'h010, 32'hEDCB_5678);
    bus_wr(12'h07C, 32'h0000_1001);
    rd_chk("R5 tog dbg1", 12'h070, 32'h0000_0001);
  endtask

  task automatic t_readonly;
    bus_wr(12'h060, 32'hFFFF_FFFF);
    bus_wr(12'h080, 32'h1111_1111);
    bus_wr(12'h044, 32'hFFFF_FFFF);
    rd_chk("R7 dbgs ro", 12'h060, 32'h0);
    rd_chk("R7 rev ro",  12'h080, 32'h0402_0000);
    rd_chk("R7 stat untouched", 12'h040, 32'hA5A5_0001);
    rd_chk("R7 stat alias", 12'h044, 32'h0);
    rd_chk("R7 rev alias", 12'h08C, 32'h0);
    rd_chk("R7 unmapped", 12'h090, 32'h0);
    rd_chk("R7 unmapped top", 12'hFFC, 32'h0);
  endtask

  task automatic t_soft;
    bus_wr(12'h050, 32'hDEAD_0000);
    bus_wr(12'h070, 32'h0000_BEEF);
    bus_wr(12'h020, 32'h0000_0055);
    bus_wr(12'h030, 32'h0000_00FF);
    rd_chk("R8 no bit31 stores", 12'h030, 32'h0000_00FF);
    rd_chk("R8 no bit31 keeps rx", 12'h020, 32'h0000_0055);
    bus_wr(12'h030, 32'h8000_0001);
    rd_chk("R8 ctl default wins", 12'h030, 32'hC020_0000);
    rd_chk("R8 rx reloaded", 12'h020, 32'h0);
    rd_chk("R8 tx reloaded", 12'h010, 32'h1006_0607);
    rd_chk("R8 pwr reloaded", 12'h000, 32'h001E_1C00);
    rd_chk("R10 dbg kept", 12'h050, 32'hDEAD_0000);
    rd_chk("R10 dbg1 kept", 12'h070, 32'h0000_BEEF);
    rd_chk("R10 stat kept", 12'h040, 32'hA5A5_0001);
    bus_wr(12'h020, 32'h0000_0066);
    bus_wr(12'h034, 32'h8000_0000);
    rd_chk("R8 set alias reload", 12'h020, 32'h0);
  endtask

  task automatic t_tog_rst;
    bus_wr(12'h020, 32'h0000_0077);
    bus_wr(12'h03C, 32'h8000_0000);
    rd_chk("R9 tog to 0 ctl", 12'h030, 32'h4020_0000);
    rd_chk("R9 tog to 0 no rst", 12'h020, 32'h0000_0077);
    bus_wr(12'h03C, 32'h8000_0000);
    rd_chk("R9 tog to 1 rst rx", 12'h020, 32'h0);
    chk("R9 tog to 1 ctl port", ctl, 32'hC020_0000);
    bus_wr(12'h020, 32'h0000_0099);
    bus_wr(12'h038, 32'h8000_0000);
    rd_chk("R9 clr ctl", 12'h030, 32'h4020_0000);
    rd_chk("R9 clr no rst", 12'h020, 32'h0000_0099);
  endtask

  task automatic t_rd_timing;
    logic [31:0] v;
    @(negedge clk);
    addr = 12'h050; rd_en = 1'b1; wr_en = 1'b1; wr_data = 32'h0000_0123;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R11 read sees old value", rd_data, 32'hDEAD_0000);
    addr = 12'h000;
    @(negedge clk);
    chk("R11 read data holds", rd_data, 32'hDEAD_0000);
    bus_rd(12'h050, v);
    chk("R11 write visible next", v, 32'h0000_0123);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R11 rd_data reset", rd_data, 32'h0);
    t_reset();
    t_direct();
    t_set();
    t_clr();
    t_tog();
    t_readonly();
    t_soft();
    t_tog_rst();
    t_rd_timing();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule